// File: doc/BRIEF.md
# Watchdog Timer with Prescaler

This block watches for software that has stopped running. A free-running tick strobe passes through a programmable power-of-two prescaler. Each prescaler output advances an 8-bit watchdog counter. If software does not clear the watchdog before the counter wraps past its top value, the block emits a one-cycle timeout pulse. The rest of the chip uses that pulse either as a reset or, while the core sleeps, as a wake-up event.

Two sticky status bits record what happened last. The timeout flag drops to 0 when the watchdog expires. The power-down flag drops to 0 when the core goes to sleep. A clear command restarts both the counter and the prescaler and sets both flags. A sleep command also restarts the counter and the prescaler, sets the timeout flag and clears the power-down flag. An enable input freezes the whole count when it is low.

Top module: `wdt_prescaled`

## Requirements
- R1: After an asynchronous reset (rstN low), toBit and pdBit read 1 and timeoutPulse reads 0. The counter and prescaler start from zero, so with preSel=0 the first timeout follows exactly 256 ticks.
- R2: With preSel=N (0 to 7), the counter advances once every 2^N enabled ticks. Starting from a clear, the timeout happens on enabled tick number 256·2^N.
- R3: timeoutPulse is high for exactly one cycle. It appears in the cycle that follows the clock edge on which the overflowing tick is taken. On that same edge toBit falls to 0, and toBit stays 0 until a clear or sleep command arrives. Counting resumes from 0, so timeouts repeat every 256·2^N ticks.
- R4: clrCmd zeroes the counter and the prescaler and sets toBit=1 and pdBit=1, visible after the next clock edge. A partly advanced prescaler count is discarded.
- R5: sleepCmd zeroes the counter and the prescaler and sets toBit=1 and pdBit=0, visible after the next clock edge. pdBit then stays 0 through later timeouts.
- R6: If clrCmd and sleepCmd arrive in the same cycle, the clear takes priority and both flags are set to 1. A tick that arrives in the same cycle as either command is not counted.
- R7: While wdtEn is low, ticks are ignored, the count holds, no timeout pulse is produced and toBit does not change. When wdtEn returns high, counting continues from the held value.
- R8: If preSel is lowered while the prescaler count already sits at or above the new divide limit, the next enabled tick wraps the prescaler to 0 and advances the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickIn | input | 1 | Time-base strobe, one count per high cycle |
| clrCmd | input | 1 | Software watchdog clear |
| sleepCmd | input | 1 | Core entering sleep |
| wdtEn | input | 1 | Counting enable |
| preSel | input | 3 | Prescaler exponent N, divides by 2^N |
| timeoutPulse | output | 1 | One-cycle expiry pulse |
| toBit | output | 1 | Timeout status, 0 after an expiry |
| pdBit | output | 1 | Power-down status, 0 after sleep |

## Verification
A wrong internal count does not show up at the pins at once. It shows only as a timeout pulse that arrives early or late, possibly tens of thousands of cycles later. For that reason every scenario predicts the exact cycle of each pulse and flags both a missing pulse and an extra one. A prescaler that keeps a stale remainder across a clear, or across a change of select, moves the expiry by a few ticks. The scenarios first preload the prescaler so that such an offset becomes visible. Errors in the flag updates appear one cycle after the command.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic clearAll;
    logic stepPresc;
    logic incCount;
  } wdtStrobeT;

  typedef struct packed {
    logic prescAtLimit;
    logic cntAtMax;
  } wdtFlagsT;
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  wdtStrobeT        stb,
  input  logic [SEL_W-1:0] preSel,
  output wdtFlagsT         flags
);
  localparam int PRESC_W = (1 << SEL_W) - 1;

  logic [PRESC_W-1:0] prescCnt;
  logic [PRESC_W-1:0] prescLimit;
  logic [CNT_W-1:0]   wdtCnt;

  // Divide limit 2^N - 1: a mask of N low ones.
  always_comb begin
    prescLimit = ~({PRESC_W{1'b1}} << preSel);
    flags.prescAtLimit = (prescCnt >= prescLimit);
    flags.cntAtMax = &wdtCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else if (stb.clearAll) begin
      prescCnt <= '0;
    end else if (stb.stepPresc) begin
      if (flags.prescAtLimit) prescCnt <= '0;
      else                    prescCnt <= prescCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdtCnt <= '0;
    end else if (stb.clearAll) begin
      wdtCnt <= '0;
    end else if (stb.incCount) begin
      wdtCnt <= wdtCnt + 1'b1;
    end
  end

  assert_clear_zeroes_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |=> (wdtCnt == '0) && (prescCnt == '0));

  assert_hold_when_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.stepPresc && !stb.clearAll) |=> ($stable(wdtCnt) && $stable(prescCnt)));

  assert_presc_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.stepPresc && flags.prescAtLimit && !stb.clearAll) |=> (prescCnt == '0));
endmodule

// File: rtl/wdt_control.sv
module wdt_control
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickIn,
  input  logic      clrCmd,
  input  logic      sleepCmd,
  input  logic      wdtEn,
  input  wdtFlagsT  flags,
  output wdtStrobeT stb,
  output logic      timeoutPulse,
  output logic      toBit,
  output logic      pdBit
);
  logic restartReq;
  logic overflowEv;

  always_comb begin
    restartReq    = clrCmd | sleepCmd;
    stb.clearAll  = restartReq;
    stb.stepPresc = tickIn & wdtEn & ~restartReq;
    stb.incCount  = stb.stepPresc & flags.prescAtLimit;
    overflowEv    = stb.incCount & flags.cntAtMax;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutPulse <= 1'b0;
      toBit        <= 1'b1;
      pdBit        <= 1'b1;
    end else begin
      timeoutPulse <= overflowEv;
      if (clrCmd) begin
        toBit <= 1'b1;
        pdBit <= 1'b1;
      end else if (sleepCmd) begin
        toBit <= 1'b1;
        pdBit <= 1'b0;
      end else if (overflowEv) begin
        toBit <= 1'b0;
      end
    end
  end

  assert_expiry_flags_R3: assert property (@(posedge clk) disable iff (!rstN)
    overflowEv |=> (timeoutPulse && !toBit));

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  assert_to_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!toBit && !clrCmd && !sleepCmd) |=> !toBit);

  assert_clear_status_R4: assert property (@(posedge clk) disable iff (!rstN)
    clrCmd |=> (toBit && pdBit));

  assert_sleep_status_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sleepCmd && !clrCmd) |=> (toBit && !pdBit));
endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
  import wdt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickIn,
  input  logic             clrCmd,
  input  logic             sleepCmd,
  input  logic             wdtEn,
  input  logic [SEL_W-1:0] preSel,
  output logic             timeoutPulse,
  output logic             toBit,
  output logic             pdBit
);
  wdtStrobeT ctlStb;
  wdtFlagsT  dpFlags;

  wdt_control u_ctl (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .clrCmd(clrCmd),
    .sleepCmd(sleepCmd), .wdtEn(wdtEn), .flags(dpFlags), .stb(ctlStb),
    .timeoutPulse(timeoutPulse), .toBit(toBit), .pdBit(pdBit)
  );

  wdt_datapath #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(ctlStb), .preSel(preSel), .flags(dpFlags)
  );

  assert_quiet_when_disabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wdtEn |=> !timeoutPulse);

  assert_idle_keeps_to_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!wdtEn && !clrCmd && !sleepCmd) |=> $stable(toBit));
endmodule

// File: tb/tb_wdt_prescaled.sv
module tb_wdt_prescaled;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int    cyc;
    bit    pulse;
    bit    to;
    bit    pd;
    string tag;
  } expT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickIn = 1'b0, clrCmd = 1'b0, sleepCmd = 1'b0, wdtEn = 1'b1;
  logic [2:0] preSel = 3'd0;
  logic timeoutPulse, toBit, pdBit;

  expT sb[$];
  int  cyc = 0;
  int  checks = 0, fails = 0;
  int  seenPulses = 0, expPulses = 0;
  bit  expTo = 1'b1, expPd = 1'b1;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_prescaled dut (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .clrCmd(clrCmd),
    .sleepCmd(sleepCmd), .wdtEn(wdtEn), .preSel(preSel),
    .timeoutPulse(timeoutPulse), .toBit(toBit), .pdBit(pdBit)
  );

  task automatic push(int c, bit p, bit t, bit d, string tag);
    expT e;
    e.cyc = c; e.pulse = p; e.to = t; e.pd = d; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: sample shortly after each rising edge and compare against the scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #2;
      if (timeoutPulse === 1'b1) seenPulses++;
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        expT e;
        e = sb.pop_front();
        checks++;
        if (e.cyc != cyc || timeoutPulse !== e.pulse || toBit !== e.to || pdBit !== e.pd) begin
          fails++;
          $display("FAIL %s @%0d: got pulse=%b to=%b pd=%b, expected pulse=%b to=%b pd=%b",
                   e.tag, cyc, timeoutPulse, toBit, pdBit, e.pulse, e.to, e.pd);
        end
      end
    end
  end

  task automatic checkStatus(string tag);
    @(negedge clk);
    push(cyc + 1, 1'b0, expTo, expPd, tag);
  endtask

  // Hold tickIn high for k edges. A pulse is expected after tick first, first+period, ...
  task automatic runTicks(int k, int first, int period, string tag);
    int base;
    bit hit;
    @(negedge clk);
    base = cyc;
    hit = 1'b0;
    if (first > 0) begin
      for (int j = first; j <= k; j += period) begin
        push(base + j, 1'b1, 1'b0, expPd, tag);
        push(base + j + 1, 1'b0, 1'b0, expPd, tag);
        expPulses++;
        hit = 1'b1;
      end
    end
    tickIn = 1'b1;
    repeat (k) @(negedge clk);
    tickIn = 1'b0;
    if (hit) expTo = 1'b0;
  endtask

  task automatic doCmd(bit c, bit s, bit tk, string tag);
    @(negedge clk);
    clrCmd = c; sleepCmd = s; tickIn = tk;
    if (c) begin expTo = 1'b1; expPd = 1'b1; end
    else if (s) begin expTo = 1'b1; expPd = 1'b0; end
    push(cyc + 1, 1'b0, expTo, expPd, tag);
    @(negedge clk);
    clrCmd = 1'b0; sleepCmd = 1'b0; tickIn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checkStatus("R1 reset state");
    runTicks(256, 256, 256, "R1 R2 first expiry sel0");
    checkStatus("R3 TO stays low");

    @(negedge clk); preSel = 3'd2;
    runTicks(3, 0, 1, "R4 preload prescaler");
    doCmd(1'b1, 1'b0, 1'b0, "R4 clear");
    runTicks(1024, 1024, 1024, "R4 prescaler discarded sel2");

    doCmd(1'b1, 1'b0, 1'b0, "R4 clear again");
    @(negedge clk); preSel = 3'd0;
    runTicks(512, 256, 256, "R3 periodic expiry");

    runTicks(100, 0, 1, "R5 partial count");
    doCmd(1'b0, 1'b1, 1'b0, "R5 sleep");
    runTicks(256, 256, 256, "R5 restart after sleep");
    checkStatus("R5 PD held");

    doCmd(1'b1, 1'b1, 1'b0, "R6 clear beats sleep");
    runTicks(255, 0, 1, "R6 preload counter");
    doCmd(1'b1, 1'b0, 1'b1, "R6 clear with tick");
    runTicks(255, 0, 1, "R6 tick not counted");
    checkStatus("R6 no early expiry");
    runTicks(1, 1, 1, "R6 expiry after full period");

    doCmd(1'b1, 1'b0, 1'b0, "R7 clear");
    runTicks(200, 0, 1, "R7 partial count");
    @(negedge clk); wdtEn = 1'b0;
    runTicks(500, 0, 1, "R7 ticks ignored");
    checkStatus("R7 TO unchanged while disabled");
    @(negedge clk); wdtEn = 1'b1;
    runTicks(56, 56, 56, "R7 resume from held count");

    doCmd(1'b1, 1'b0, 1'b0, "R8 clear");
    @(negedge clk); preSel = 3'd7;
    runTicks(5, 0, 1, "R8 preload at sel7");
    @(negedge clk); preSel = 3'd2;
    runTicks(1021, 1021, 1021, "R8 select lowered");

    doCmd(1'b1, 1'b0, 1'b0, "R2 clear");
    @(negedge clk); preSel = 3'd3;
    runTicks(2048, 2048, 2048, "R2 sel3 expiry");

    repeat (4) @(negedge clk);
    checks++;
    if (seenPulses != expPulses) begin
      fails++;
      $display("FAIL R3 R7 pulse count: got %0d, expected %0d", seenPulses, expPulses);
    end
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R3 scoreboard drain: got %0d pending, expected 0", sb.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule